// File: doc/BRIEF.md
# Two-Stage Nested Address Translation Walker

This block translates a guest virtual address into a host physical address for a virtual machine. It does this with no help from any translation cache. The guest owns a radix table that maps guest virtual to guest physical addresses. The host owns a second radix table that maps guest physical to host physical addresses. Every pointer found in the guest table, and the guest root pointer itself, is a guest physical address. Each one therefore goes through a complete host-table walk before the guest table can be read at that location. The guest physical address produced by the last guest level is then walked through the host table one more time.

A request is taken in a single cycle. It carries the guest virtual address, the guest root pointer (a guest physical address) and the host root pointer (a host physical address). The walker then issues table reads one at a time on a single read port. The memory system may return each entry after any number of cycles. At the end the walker pulses `done` and holds the result: either the host physical address, or a fault that names the stage and level at which an invalid entry was found. A counter of host-table reads lets the cost of the walk be seen outside the block.

Top module: `nested_walker`

## Requirements
- R1: After reset, `busy`, `done`, `mem_req`, `fault` and `nref_cnt` are all 0.
- R2: Each host-table read targets `base + 8*idx`. The base is the host root for the first read of every host walk, and after that the frame of the previous entry. `idx` is the 9-bit field of the guest physical address being translated, taken from the most significant field down to the field just above the 12-bit page offset.
- R3: The walk starts with a host walk of the guest root pointer. Each guest-table read targets the host-translated table base plus 8 times the 9-bit field of the guest virtual address for that level, most significant level first.
- R4: After the last guest level, the guest physical address is the leaf frame joined with bits 11:0 of the guest virtual address. It is walked through the host table. `hpa` equals that final host frame joined with the same 12 offset bits.
- R5: A table entry is valid when bit 0 is 1. Its frame is bits 47:12. Bits 11:1 and bits 63:48 have no effect on the result.
- R6: On a successful translation, `nref_cnt` equals GLVL*NLVL+NLVL, and exactly GLVL*NLVL+GLVL+NLVL reads are issued.
- R7: On a read that returns an invalid entry, the walk stops and issues no further reads. It sets `fault`. `fault_nested` is 1 for a host-table entry and 0 for a guest-table entry. `fault_level` gives the level inside that stage, with 0 as the top level. `nref_cnt` counts host reads up to and including the faulting one.
- R8: `mem_req` is high for one cycle per read, only while `busy`, and no new read is issued until `mem_rvalid` has returned the previous one.
- R9: `req_valid` is ignored while `busy` is high; the result is that of the request already in progress.
- R10: `done` is a one-cycle pulse with `busy` low. `hpa`, `fault`, `fault_nested`, `fault_level` and `nref_cnt` hold their values until the next request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Start a translation (taken only when idle) |
| req_gva | input | 48 | Guest virtual address |
| guest_root | input | 48 | Guest top-level table pointer, a guest physical address |
| nest_root | input | 48 | Host top-level table pointer, a host physical address |
| busy | output | 1 | A translation is in progress |
| mem_req | output | 1 | One-cycle read request |
| mem_addr | output | 48 | Host physical address of the entry to read |
| mem_rdata | input | 64 | Returned table entry |
| mem_rvalid | input | 1 | `mem_rdata` is valid this cycle |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | The translation ended on an invalid entry |
| fault_nested | output | 1 | The fault came from the host table (1) or the guest table (0) |
| fault_level | output | 3 | Level inside the faulting stage, 0 = top |
| hpa | output | 48 | Translated host physical address |
| nref_cnt | output | 5 | Host-table reads made by the current or last translation |

## Verification
The bench places an invalid entry at every one of the 24 read positions of a walk in turn. A walker that mixed up the stage or level would report the wrong `fault_nested` or `fault_level`. One that kept walking after a fault would show an extra read. One that counted the faulting read wrongly would report a `nref_cnt` that is off by one. Every address issued is compared with a model that computes the table contents arithmetically from the address. This exposes a host walk that forgets to restart from the host root, reuses a stale base, takes the index from the wrong address or the wrong field, or drops the page offset on the final pass. Entry flag bits and high bits carry junk, so a design that used them would produce wrong frames. A stray request raised mid-walk checks that a busy walker does not restart.

// File: rtl/nested_walker.sv
module nested_walker #(
  parameter int GLVL  = 4,
  parameter int NLVL  = 4,
  parameter int IDX   = 9,
  parameter int PGOFF = 12,
  parameter int EW    = 64,
  localparam int VA_W = GLVL*IDX + PGOFF,
  localparam int PA_W = NLVL*IDX + PGOFF,
  localparam int NMAX = GLVL*NLVL + NLVL,
  localparam int CW   = $clog2(NMAX + 1),
  localparam int LW   = $clog2((GLVL > NLVL ? GLVL : NLVL) + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic [VA_W-1:0] req_gva,
  input  logic [PA_W-1:0] guest_root,
  input  logic [PA_W-1:0] nest_root,
  output logic            busy,
  output logic            mem_req,
  output logic [PA_W-1:0] mem_addr,
  input  logic [EW-1:0]   mem_rdata,
  input  logic            mem_rvalid,
  output logic            done,
  output logic            fault,
  output logic            fault_nested,
  output logic [LW-1:0]   fault_level,
  output logic [PA_W-1:0] hpa,
  output logic [CW-1:0]   nref_cnt
);
  localparam int ESH = $clog2(EW/8);
  localparam int GW  = $clog2(GLVL + 1);
  localparam int NW  = $clog2(NLVL + 1);

  typedef enum logic [2:0] {S_IDLE, S_NREQ, S_NWAIT, S_GREQ, S_GWAIT} st_t;
  st_t state;

  logic [VA_W-1:0] gva;
  logic [PA_W-1:0] tgt, nbase, nroot, gbase, frame;
  logic [GW-1:0]   glvl;
  logic [NW-1:0]   nlvl;
  logic [IDX-1:0]  n_idx, g_idx;
  logic            ent_ok;

  assign busy    = (state != S_IDLE);
  assign mem_req = (state == S_NREQ) || (state == S_GREQ);
  assign frame   = {mem_rdata[PA_W-1:PGOFF], {PGOFF{1'b0}}};
  assign ent_ok  = mem_rdata[0];

  always_comb begin
    n_idx = IDX'(tgt >> (PGOFF + IDX*(NLVL-1-int'(nlvl))));
    g_idx = IDX'(gva >> (PGOFF + IDX*(GLVL-1-int'(glvl))));
    if (state == S_GREQ) mem_addr = gbase + (PA_W'(g_idx) << ESH);
    else                 mem_addr = nbase + (PA_W'(n_idx) << ESH);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE; gva <= '0; tgt <= '0; nbase <= '0; nroot <= '0; gbase <= '0;
      glvl <= '0; nlvl <= '0; done <= 1'b0; fault <= 1'b0; fault_nested <= 1'b0;
      fault_level <= '0; hpa <= '0; nref_cnt <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: if (req_valid) begin
          gva <= req_gva; tgt <= guest_root; nbase <= nest_root; nroot <= nest_root;
          glvl <= '0; nlvl <= '0; nref_cnt <= '0; hpa <= '0;
          fault <= 1'b0; fault_nested <= 1'b0; fault_level <= '0;
          state <= S_NREQ;
        end
        S_NREQ: begin
          nref_cnt <= nref_cnt + 1'b1;
          state    <= S_NWAIT;
        end
        S_NWAIT: if (mem_rvalid) begin
          if (!ent_ok) begin
            fault <= 1'b1; fault_nested <= 1'b1; fault_level <= LW'(nlvl);
            done <= 1'b1; state <= S_IDLE;
          end else if (int'(nlvl) == NLVL-1) begin
            if (int'(glvl) == GLVL) begin
              hpa   <= frame | {{(PA_W-PGOFF){1'b0}}, tgt[PGOFF-1:0]};
              done  <= 1'b1;
              state <= S_IDLE;
            end else begin
              gbase <= frame;
              state <= S_GREQ;
            end
          end else begin
            nlvl  <= nlvl + 1'b1;
            nbase <= frame;
            state <= S_NREQ;
          end
        end
        S_GREQ: state <= S_GWAIT;
        S_GWAIT: if (mem_rvalid) begin
          if (!ent_ok) begin
            fault <= 1'b1; fault_nested <= 1'b0; fault_level <= LW'(glvl);
            done <= 1'b1; state <= S_IDLE;
          end else begin
            tgt   <= frame | ((int'(glvl) == GLVL-1) ?
                     {{(PA_W-PGOFF){1'b0}}, gva[PGOFF-1:0]} : '0);
            glvl  <= glvl + 1'b1;
            nlvl  <= '0;
            nbase <= nroot;
            state <= S_NREQ;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/nested_walker_chk.sv
module nested_walker_chk #(
  parameter int GLVL = 4,
  parameter int NLVL = 4,
  parameter int CW   = 5,
  parameter int LW   = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          mem_req,
  input logic          mem_rvalid,
  input logic          done,
  input logic          fault,
  input logic          fault_nested,
  input logic [LW-1:0] fault_level,
  input logic [CW-1:0] nref_cnt
);
  localparam int NMAX = GLVL*NLVL + NLVL;
  logic outst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          outst <= 1'b0;
    else if (mem_req)    outst <= 1'b1;
    else if (mem_rvalid) outst <= 1'b0;
  end

  p_single_read_r8: assert property (@(posedge clk) disable iff (!rst_n) mem_req |-> !outst);
  p_req_busy_r8:    assert property (@(posedge clk) disable iff (!rst_n) mem_req |-> busy);
  p_done_idle_r10:  assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy);
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  p_nref_bound_r6:  assert property (@(posedge clk) disable iff (!rst_n) nref_cnt <= CW'(NMAX));
  p_ok_count_r6:    assert property (@(posedge clk) disable iff (!rst_n)
                      (done && !fault) |-> nref_cnt == CW'(NMAX));
  p_glevel_r7:      assert property (@(posedge clk) disable iff (!rst_n)
                      (done && fault && !fault_nested) |-> int'(fault_level) < GLVL);
  p_nlevel_r7:      assert property (@(posedge clk) disable iff (!rst_n)
                      (done && fault && fault_nested) |-> int'(fault_level) < NLVL);
endmodule

bind nested_walker nested_walker_chk #(.GLVL(GLVL), .NLVL(NLVL), .CW(CW), .LW(LW)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .mem_req(mem_req), .mem_rvalid(mem_rvalid),
  .done(done), .fault(fault), .fault_nested(fault_nested), .fault_level(fault_level),
  .nref_cnt(nref_cnt)
);

// File: tb/nested_walker_tb.sv
`timescale 1ns/1ps
module nested_walker_tb;
  localparam int GL = 4, NL = 4;
  localparam int TOT = GL*NL + GL + NL;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0;
  logic [47:0] req_gva = '0, guest_root = '0, nest_root = '0;
  logic busy, mem_req, mem_rvalid = 0, done, fault, fault_nested;
  logic [47:0] mem_addr, hpa;
  logic [63:0] mem_rdata = '0;
  logic [2:0] fault_level;
  logic [4:0] nref_cnt;

  always #2.5 clk = ~clk;

  nested_walker u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_gva(req_gva),
    .guest_root(guest_root), .nest_root(nest_root), .busy(busy), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_rdata(mem_rdata), .mem_rvalid(mem_rvalid), .done(done),
    .fault(fault), .fault_nested(fault_nested), .fault_level(fault_level), .hpa(hpa),
    .nref_cnt(nref_cnt)
  );

  int checks = 0, fails = 0;
  logic [47:0] exp_addr [0:31];
  int m_n, m_nref, m_level, inj = -1, refn = 0, addr_err = 0, pend = 0, lat = 0;
  bit m_fault, m_nested;
  logic [47:0] m_hpa;
  logic [63:0] resp;

  function automatic logic [63:0] ent(input logic [47:0] a);
    logic [63:0] h = ({16'h0, a} >> 3) * 64'd2654435761 + 64'd977;
    return {16'hA5C3, h[35:0], a[13:3], 1'b1};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic model(input logic [47:0] gva, groot, nroot, input int k);
    logic [47:0] tgt, base, a;
    logic [63:0] e;
    int p = 0;
    bit stop = 0;
    m_fault = 0; m_nested = 0; m_level = 0; m_nref = 0; m_hpa = '0; tgt = groot;
    for (int g = 0; g <= GL && !stop; g++) begin
      base = nroot;
      for (int l = 0; l < NL && !stop; l++) begin
        a = base + (((tgt >> (12 + 9*(NL-1-l))) & 48'h1FF) << 3);
        exp_addr[p] = a; m_nref++;
        if (p == k) begin m_fault = 1; m_nested = 1; m_level = l; stop = 1; end
        else begin e = ent(a); base = {e[47:12], 12'h0}; end
        p++;
      end
      if (!stop) begin
        if (g == GL) m_hpa = base | {36'h0, tgt[11:0]};
        else begin
          a = base + (((gva >> (12 + 9*(GL-1-g))) & 48'h1FF) << 3);
          exp_addr[p] = a;
          if (p == k) begin m_fault = 1; m_nested = 0; m_level = g; stop = 1; end
          else begin e = ent(a); tgt = {e[47:12], (g == GL-1) ? gva[11:0] : 12'h0}; end
          p++;
        end
      end
    end
    m_n = p;
  endtask

  always @(negedge clk) begin
    if (mem_rvalid) mem_rvalid = 0;
    if (pend != 0) begin
      if (lat == 0) begin mem_rvalid = 1; mem_rdata = resp; pend = 0; end
      else lat--;
    end
    if (mem_req) begin
      if (refn >= m_n || mem_addr !== exp_addr[refn]) addr_err++;
      resp = ent(mem_addr);
      if (refn == inj) resp[0] = 1'b0;
      refn++; pend = 1; lat = int'(mem_addr[4:3]);
    end
  end

  task automatic run(input logic [47:0] gva, groot, nroot, input int k, input bit stray);
    int t = 0;
    model(gva, groot, nroot, k);
    inj = k; refn = 0; addr_err = 0;
    @(negedge clk);
    req_valid = 1; req_gva = gva; guest_root = groot; nest_root = nroot;
    @(negedge clk);
    req_valid = 0;
    if (stray) begin
      repeat (3) @(negedge clk);
      req_valid = 1; req_gva = ~gva; guest_root = nroot; nest_root = groot;
      @(negedge clk);
      req_valid = 0;
    end
    while (!done && t < 3000) begin @(negedge clk); t++; end
    chk(t < 3000, "R8 walk completes (watchdog)", t, 3000);
    chk(!busy, "R10 busy low with done", busy, 0);
    chk(fault == m_fault, stray ? "R9 fault after stray request" : "R7 fault flag", fault, m_fault);
    chk(hpa == m_hpa, m_fault ? "R10 hpa cleared on fault" : "R4 R5 translated hpa", hpa, m_hpa);
    chk(nref_cnt == 5'(m_nref), m_fault ? "R7 nested count at fault" : "R6 nested count", nref_cnt, m_nref);
    chk(refn == m_n, "R6 R7 total reads issued", refn, m_n);
    chk(addr_err == 0, "R2 R3 read addresses", addr_err, 0);
    if (m_fault) begin
      chk(fault_nested == m_nested, "R7 fault stage", fault_nested, m_nested);
      chk(int'(fault_level) == m_level, "R7 fault level", fault_level, m_level);
    end
    @(negedge clk);
    chk(!done, "R10 done single pulse", done, 0);
    repeat (3) @(negedge clk);
    chk(hpa == m_hpa && fault == m_fault && nref_cnt == 5'(m_nref), "R10 results held", hpa, m_hpa);
  endtask

  initial begin
    #900000;
    checks++; fails++;
    $display("FAIL watchdog expired actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    m_n = 0;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !mem_req && !fault && nref_cnt == 0, "R1 reset state",
        {busy, done, mem_req, fault, nref_cnt}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(!busy && !mem_req, "R1 idle after reset", {busy, mem_req}, 0);

    run(48'h0, 48'h0, 48'h0, -1, 0);
    run(48'hFFFF_FFFF_FFFF, 48'h0000_1234_5000, 48'h0007_7700_0000, -1, 0);
    for (int i = 0; i < 16; i++)
      run(48'h1357_9BDF_0000 ^ (48'(i) * 48'h0401_8037_2A53), 48'h0000_00AB_C000 + 48'(i) * 48'h1000,
          48'h0000_4000_0000 + 48'(i) * 48'h20_0000, -1, 0);
    for (int k = 0; k < TOT; k++)
      run(48'h7654_3210_FEDC, 48'h0000_0055_5000, 48'h0001_0000_0000, k, 0);
    run(48'h0BAD_CAFE_0123, 48'h0000_0F00_0000, 48'h0002_0000_0000, -1, 1);
    run(48'h0BAD_CAFE_0123, 48'h0000_0F00_0000, 48'h0002_0000_0000, 9, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule